// File: doc/BRIEF.md
# Burst Write Command Sequencer

This block turns one write request into the command, address and data-enable timeline a DDR2-style memory expects for a single burst write. A request carries a bank, a row and a column. The sequencer opens the row and waits out the row-to-column delay. It then issues the column write and drives the strobe and data enables once the write latency has passed. It counts the burst beats and holds the bank precharge back until write recovery has elapsed. The model works at single data rate: each beat occupies one clock, and the output is the command slot plus enables rather than real double-edge I/O.

Additive latency, CAS latency, row-to-column delay, write recovery and burst length are plain configuration pins. They are sampled into the block when a request is accepted. The write latency is additive latency plus CAS latency minus one. Because additive latency delays the write inside the memory, the write command may be issued that many cycles early. It never goes out earlier than one cycle after the activate. A CAS latency value below 2 is treated as 2.

The request port is valid/ready. `req_ready` is high only while the block is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high, and `req_valid` may stay high across a busy period without effect. The write-data port is also valid/ready, but the block sets the pace: `wd_ready` rises exactly in the cycle before each beat slot, and the data present on that edge becomes the beat. The block never stalls the burst. If `wd_valid` is low when a slot is taken, that beat is driven as all zeros.

Top module: `burst_write_seq`

## Requirements
- R1: `req_ready` is high exactly when no burst is in progress. A request is accepted on an edge with `req_valid` and `req_ready` both high. The cycle after acceptance carries the activate command with the request's row on `addr_o` and its bank on `ba_o`. No other activate appears during a burst, even with `req_valid` held high.
- R2: The write command comes G cycles after the activate, with G = max(1, tRCD - AL). It carries the request's column on `addr_o` and its bank on `ba_o`.
- R3: The first data beat (`dq_oe` high) comes WL = AL + CL - 1 cycles after the write command.
- R4: Beats occupy consecutive cycles, and their number is the burst length: 8 when `cfg_bl8` is 1, 4 when it is 0.
- R5: `wd_ready` is high exactly in the cycle before each beat slot. Beat k carries the data presented on the k-th handshake, in order.
- R6: Outside the beat slots, `wd_ready` is low and `dq_oe` is low, and `dq_o` is all zeros, even while `wd_valid` stays high after the burst.
- R7: `dqs_oe` is high from one cycle before the first beat through the last beat, and low otherwise.
- R8: The precharge command comes tWR + 1 cycles after the last beat, with the request's bank on `ba_o` and zero on `addr_o`. `req_ready` is high in the following cycle.
- R9: The command encoding is NOP = 0, activate = 1, write = 2, precharge = 3. Every other cycle carries NOP, with `ba_o` and `addr_o` at zero.
- R10: The configuration pins are sampled only on acceptance. Changing them during a burst leaves that burst's timing unchanged.
- R11: While reset (`rst_n` low) is applied and just after, the block is idle: `req_ready` is 1, the command is NOP, and `wd_ready`, `dqs_oe` and `dq_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_al | input | AL_W | Additive latency in cycles |
| cfg_cl | input | CL_W | CAS latency in cycles (values below 2 are treated as 2) |
| cfg_trcd | input | TRCD_W | Minimum activate-to-column delay |
| cfg_twr | input | TWR_W | Write recovery cycles between the last beat and precharge |
| cfg_bl8 | input | 1 | Burst length select: 1 gives 8 beats, 0 gives 4 |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Row to open |
| req_col | input | COL_W | Starting column |
| wd_valid | input | 1 | Write data offered |
| wd_ready | output | 1 | A beat slot follows; data is taken at this edge |
| wd_data | input | DATA_W | Write data |
| cmd_o | output | 2 | Command slot (NOP/ACT/WR/PRE) |
| ba_o | output | BANK_W | Bank address for the command |
| addr_o | output | ADDR_W | Row or column address for the command |
| dqs_oe | output | 1 | Strobe output enable, including the preamble |
| dq_oe | output | 1 | Data output enable, one per beat |
| dq_o | output | DATA_W | Data beat |

## Verification
Two functions can land in the same cycle. The first pair is the write command and the strobe preamble. With AL = 0 and CL = 2 the write latency is one cycle, so `dqs_oe` must rise in the very cycle that carries the write command. The second pair is the end of the data burst and the precharge. With tWR = 0 the precharge must follow the last beat directly, in the same cycle that `dqs_oe` falls. The bench sweeps every combination of AL 0 to 2, CL 2 to 4, tRCD 1 to 4, tWR 0 to 2 and both burst lengths. For each burst it predicts the full timeline arithmetically and compares every output in every cycle, so both pairs are judged wherever they coincide.

// File: rtl/bws_pkg.sv
package bws_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_WR  = 2'd2,
    CMD_PRE = 2'd3
  } bws_cmd_e;

  localparam int unsigned BL_SHORT = 4;
  localparam int unsigned BL_LONG  = 8;
  localparam int unsigned CL_FLOOR = 2;

endpackage

// File: rtl/bws_timing.sv
module bws_timing
  import bws_pkg::*;
#(
  parameter int AL_W   = 3,
  parameter int CL_W   = 3,
  parameter int TRCD_W = 4,
  parameter int TWR_W  = 4,
  parameter int T_W    = 7
) (
  input  logic [AL_W-1:0]   al,
  input  logic [CL_W-1:0]   cl,
  input  logic [TRCD_W-1:0] trcd,
  input  logic [TWR_W-1:0]  twr,
  input  logic              bl8,
  output logic [T_W-1:0]    t_wr,
  output logic [T_W-1:0]    t_beat0,
  output logic [T_W-1:0]    t_last,
  output logic [T_W-1:0]    t_pre
);

  logic [T_W-1:0] al_t, cl_t, trcd_t, twr_t, gap, wl, bl_t;

  // Milestones are offsets counted from the activate cycle.
  always_comb begin
    al_t   = T_W'(al);
    cl_t   = T_W'(cl);
    trcd_t = T_W'(trcd);
    twr_t  = T_W'(twr);
    if (cl_t < T_W'(CL_FLOOR)) cl_t = T_W'(CL_FLOOR);
    // write may go out early by AL, never in the activate cycle itself
    gap     = (trcd_t > al_t + T_W'(1)) ? (trcd_t - al_t) : T_W'(1);
    wl      = al_t + cl_t - T_W'(1);
    bl_t    = bl8 ? T_W'(BL_LONG) : T_W'(BL_SHORT);
    t_wr    = gap;
    t_beat0 = gap + wl;
    t_last  = gap + wl + bl_t - T_W'(1);
    t_pre   = gap + wl + bl_t + twr_t;
  end

endmodule

// File: rtl/bws_cmd.sv
module bws_cmd
  import bws_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 10,
  parameter int ADDR_W = 14,
  parameter int T_W    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [T_W-1:0]    t_wr,
  input  logic [T_W-1:0]    t_pre,
  output logic              accept,
  output logic              active,
  output logic [T_W-1:0]    t_now,
  output logic [1:0]        cmd_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ADDR_W-1:0] addr_o
);

  logic              active_q;
  logic [T_W-1:0]    t_q;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  bws_cmd_e          cmd;

  assign req_ready = !active_q;
  assign accept    = req_valid && !active_q;
  assign active    = active_q;
  assign t_now     = t_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      t_q      <= '0;
      bank_q   <= '0;
      row_q    <= '0;
      col_q    <= '0;
    end else if (accept) begin
      active_q <= 1'b1;
      t_q      <= '0;
      bank_q   <= req_bank;
      row_q    <= req_row;
      col_q    <= req_col;
    end else if (active_q) begin
      if (t_q == t_pre) begin
        active_q <= 1'b0;
        t_q      <= '0;
      end else begin
        t_q <= t_q + T_W'(1);
      end
    end
  end

  always_comb begin
    cmd    = CMD_NOP;
    ba_o   = '0;
    addr_o = '0;
    if (active_q) begin
      if (t_q == '0) begin
        cmd    = CMD_ACT;
        ba_o   = bank_q;
        addr_o = ADDR_W'(row_q);
      end else if (t_q == t_wr) begin
        cmd    = CMD_WR;
        ba_o   = bank_q;
        addr_o = ADDR_W'(col_q);
      end else if (t_q == t_pre) begin
        cmd    = CMD_PRE;
        ba_o   = bank_q;
      end
    end
  end

  assign cmd_o = cmd;

  AST_ACCEPT_OPENS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cmd_o == CMD_ACT)); // R1
  AST_ACT_ONLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_ACT) |-> $past(req_valid && req_ready)); // R1
  AST_WR_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_WR) |-> !req_ready); // R2
  AST_PRE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_PRE) |=> req_ready); // R8
  AST_NOP_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_NOP) |-> (addr_o == '0 && ba_o == '0)); // R9

endmodule

// File: rtl/bws_beat.sv
module bws_beat
  import bws_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int T_W    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [T_W-1:0]    t_now,
  input  logic [T_W-1:0]    t_beat0,
  input  logic [T_W-1:0]    t_last,
  input  logic              bl8,
  input  logic              wd_valid,
  output logic              wd_ready,
  input  logic [DATA_W-1:0] wd_data,
  output logic              dqs_oe,
  output logic              dq_oe,
  output logic [DATA_W-1:0] dq_o
);

  logic [T_W-1:0]    t_next;
  logic              dq_oe_q;
  logic [DATA_W-1:0] dq_q;
  logic [3:0]        beats_q;
  logic [3:0]        bl_n;

  assign t_next   = t_now + T_W'(1);
  // slot ahead: the handshake on this edge fills the next cycle's beat
  assign wd_ready = active && (t_next >= t_beat0) && (t_next <= t_last);
  // strobe preamble starts one cycle ahead of the first beat
  assign dqs_oe   = active && (t_next >= t_beat0) && (t_now <= t_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dq_oe_q <= 1'b0;
      dq_q    <= '0;
    end else if (wd_ready) begin
      dq_oe_q <= 1'b1;
      dq_q    <= wd_valid ? wd_data : '0;
    end else begin
      dq_oe_q <= 1'b0;
      dq_q    <= '0;
    end
  end

  assign dq_oe = dq_oe_q;
  assign dq_o  = dq_q;

  // beat tally used by the checks below
  assign bl_n = bl8 ? 4'(BL_LONG) : 4'(BL_SHORT);

  always_ff @(posedge clk) begin
    if (!rst_n || !active) beats_q <= '0;
    else if (dq_oe_q)      beats_q <= beats_q + 4'd1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    beats_q <= bl_n); // R4
  AST_PREAMBLE_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> $past(dqs_oe)); // R7
  AST_STROBE_COVERS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> dqs_oe); // R7
  AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_o == '0)); // R6
  AST_BEAT_FOLLOWS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    wd_ready |=> dq_oe); // R5

endmodule

// File: rtl/burst_write_seq.sv
module burst_write_seq
  import bws_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 10,
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16,
  parameter int AL_W   = 3,
  parameter int CL_W   = 3,
  parameter int TRCD_W = 4,
  parameter int TWR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AL_W-1:0]   cfg_al,
  input  logic [CL_W-1:0]   cfg_cl,
  input  logic [TRCD_W-1:0] cfg_trcd,
  input  logic [TWR_W-1:0]  cfg_twr,
  input  logic              cfg_bl8,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              wd_valid,
  output logic              wd_ready,
  input  logic [DATA_W-1:0] wd_data,
  output logic [1:0]        cmd_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              dqs_oe,
  output logic              dq_oe,
  output logic [DATA_W-1:0] dq_o
);

  localparam int T_MAX = (1 << TRCD_W) + (1 << AL_W) + 2 * (1 << CL_W)
                       + (1 << TWR_W) + int'(BL_LONG);
  localparam int T_W   = $clog2(T_MAX) + 1;

  logic [AL_W-1:0]   al_q;
  logic [CL_W-1:0]   cl_q;
  logic [TRCD_W-1:0] trcd_q;
  logic [TWR_W-1:0]  twr_q;
  logic              bl8_q;
  logic              accept, active;
  logic [T_W-1:0]    t_now, t_wr, t_beat0, t_last, t_pre;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      al_q   <= '0;
      cl_q   <= CL_W'(CL_FLOOR);
      trcd_q <= '0;
      twr_q  <= '0;
      bl8_q  <= 1'b0;
    end else if (accept) begin
      al_q   <= cfg_al;
      cl_q   <= cfg_cl;
      trcd_q <= cfg_trcd;
      twr_q  <= cfg_twr;
      bl8_q  <= cfg_bl8;
    end
  end

  bws_timing #(
    .AL_W(AL_W), .CL_W(CL_W), .TRCD_W(TRCD_W), .TWR_W(TWR_W), .T_W(T_W)
  ) timing_i (
    .al(al_q), .cl(cl_q), .trcd(trcd_q), .twr(twr_q), .bl8(bl8_q),
    .t_wr(t_wr), .t_beat0(t_beat0), .t_last(t_last), .t_pre(t_pre)
  );

  bws_cmd #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .T_W(T_W)
  ) cmd_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .t_wr(t_wr), .t_pre(t_pre),
    .accept(accept), .active(active), .t_now(t_now),
    .cmd_o(cmd_o), .ba_o(ba_o), .addr_o(addr_o)
  );

  bws_beat #(
    .DATA_W(DATA_W), .T_W(T_W)
  ) beat_i (
    .clk(clk), .rst_n(rst_n),
    .active(active), .t_now(t_now), .t_beat0(t_beat0), .t_last(t_last),
    .bl8(bl8_q),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .dqs_oe(dqs_oe), .dq_oe(dq_oe), .dq_o(dq_o)
  );

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !$past(accept)) |-> ($stable(al_q) && $stable(cl_q) && $stable(twr_q))); // R10

endmodule

// File: tb/burst_write_seq_tb_top.sv
module burst_write_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  cfg_al, cfg_cl;
  logic [3:0]  cfg_trcd, cfg_twr;
  logic        cfg_bl8;
  logic        req_valid, req_ready;
  logic [2:0]  req_bank;
  logic [13:0] req_row;
  logic [9:0]  req_col;
  logic        wd_valid, wd_ready;
  logic [15:0] wd_data;
  logic [1:0]  cmd_o;
  logic [2:0]  ba_o;
  logic [13:0] addr_o;
  logic        dqs_oe, dq_oe;
  logic [15:0] dq_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  burst_write_seq dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_al(cfg_al), .cfg_cl(cfg_cl), .cfg_trcd(cfg_trcd), .cfg_twr(cfg_twr),
    .cfg_bl8(cfg_bl8),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .cmd_o(cmd_o), .ba_o(ba_o), .addr_o(addr_o),
    .dqs_oe(dqs_oe), .dq_oe(dq_oe), .dq_o(dq_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] pat(input int id, input int k);
    return 16'((id * 613 + k * 97 + 16'h0a5) & 16'hffff);
  endfunction

  task automatic run_burst(input int id, input int al, input int cl, input int trcd,
                           input int twr, input bit bl8);
    int gap, wl, bl, b0, last, tp, taken;
    int e_cmd, e_addr, e_ba;
    logic [13:0] row;
    logic [9:0]  col;
    logic [2:0]  bank;
    gap  = (trcd - al > 1) ? trcd - al : 1;
    wl   = al + cl - 1;
    bl   = bl8 ? 8 : 4;
    b0   = gap + wl;
    last = b0 + bl - 1;
    tp   = last + twr + 1;
    row  = 14'((id * 131 + 5) & 16'h3fff);
    col  = 10'((id * 29 + 3) & 10'h3ff);
    bank = 3'(id % 8);
    // R1: idle before the request
    chk(req_ready == 1'b1, "R1 ready before accept", int'(req_ready), 1);
    req_valid = 1'b1; req_bank = bank; req_row = row; req_col = col;
    cfg_al = 3'(al); cfg_cl = 3'(cl); cfg_trcd = 4'(trcd); cfg_twr = 4'(twr); cfg_bl8 = bl8;
    wd_valid = 1'b1; wd_data = 16'hdead;
    @(posedge clk); @(negedge clk);
    // R10: scramble config; R1: keep offering a bogus request
    cfg_al = 3'd7; cfg_cl = 3'd7; cfg_trcd = 4'd15; cfg_twr = 4'd15; cfg_bl8 = ~bl8;
    req_row = ~row; req_col = ~col; req_bank = ~bank;
    taken = 0;
    for (int t = 0; t <= tp + 1; t++) begin
      if (t <= tp) begin
        e_cmd = 0; e_addr = 0; e_ba = 0;
        if (t == 0)        begin e_cmd = 1; e_addr = int'(row); e_ba = int'(bank); end
        else if (t == gap) begin e_cmd = 2; e_addr = int'(col); e_ba = int'(bank); end
        else if (t == tp)  begin e_cmd = 3; e_ba = int'(bank); end
        if (t == 0)        chk(int'(cmd_o) == e_cmd, "R1 activate", int'(cmd_o), e_cmd);
        else if (t == gap) chk(int'(cmd_o) == e_cmd, "R2 write cmd", int'(cmd_o), e_cmd);
        else if (t == tp)  chk(int'(cmd_o) == e_cmd, "R8 precharge", int'(cmd_o), e_cmd);
        else               chk(int'(cmd_o) == e_cmd, "R9 nop slot", int'(cmd_o), e_cmd);
        chk(int'(addr_o) == e_addr, "R9 addr", int'(addr_o), e_addr);
        chk(int'(ba_o) == e_ba, "R8 bank", int'(ba_o), e_ba);
        chk(req_ready == 1'b0, "R1 busy", int'(req_ready), 0);
        chk(dq_oe == (t >= b0 && t <= last), "R3 dq_oe window", int'(dq_oe),
            int'(t >= b0 && t <= last));
        chk(dqs_oe == (t >= b0 - 1 && t <= last), "R7 dqs_oe window", int'(dqs_oe),
            int'(t >= b0 - 1 && t <= last));
        chk(wd_ready == (t >= b0 - 1 && t <= last - 1), "R5 wd_ready slot", int'(wd_ready),
            int'(t >= b0 - 1 && t <= last - 1));
        if (t >= b0 && t <= last)
          chk(dq_o == pat(id, t - b0), "R4 beat data", int'(dq_o), int'(pat(id, t - b0)));
        else
          chk(dq_o == 16'h0, "R6 data quiet", int'(dq_o), 0);
      end else begin
        chk(req_ready == 1'b1, "R8 ready after precharge", int'(req_ready), 1);
        chk(int'(cmd_o) == 0, "R9 idle nop", int'(cmd_o), 0);
        chk(taken == bl, "R4 beat count", taken, bl);
      end
      wd_valid = 1'b1;
      wd_data  = pat(id, taken);
      if (wd_ready) taken++;
      if (t == tp) req_valid = 1'b0;
      if (t <= tp) begin
        @(posedge clk); @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int id;
    rst_n = 1'b0;
    req_valid = 1'b0; req_bank = '0; req_row = '0; req_col = '0;
    wd_valid = 1'b0; wd_data = '0;
    cfg_al = '0; cfg_cl = 3'd2; cfg_trcd = 4'd1; cfg_twr = '0; cfg_bl8 = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1, "R11 reset ready", int'(req_ready), 1);
    chk(int'(cmd_o) == 0, "R11 reset cmd", int'(cmd_o), 0);
    chk(dq_oe == 1'b0 && dqs_oe == 1'b0, "R11 reset enables", int'(dq_oe | dqs_oe), 0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(wd_ready == 1'b0, "R11 idle wd_ready", int'(wd_ready), 0);
    chk(req_ready == 1'b1, "R11 idle ready", int'(req_ready), 1);
    id = 0;
    for (int al = 0; al <= 2; al++)
      for (int cl = 2; cl <= 4; cl++)
        for (int trcd = 1; trcd <= 4; trcd++)
          for (int twr = 0; twr <= 2; twr++)
            for (int b = 0; b <= 1; b++) begin
              run_burst(id, al, cl, trcd, twr, b[0]);
              id++;
            end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule